// File: doc/BRIEF.md
# Transmit Mailbox Completion and Interrupt Flags

This block keeps the per-mailbox state that changes when a transmit mailbox finishes sending a frame. A completion strobe arrives with a mailbox index and the current value of a free-running timer. On the next clock edge the block records that timer value as the mailbox timestamp. It moves the mailbox code to its post-transmission value and sets the mailbox's interrupt flag. A single interrupt line goes high whenever any flagged mailbox also has its mask bit set.

A CPU port writes the mailbox control words, the interrupt mask and the flag register, and reads them back. Flags clear when the CPU writes a one to them. When abort mode is on, a raised flag also acts as a write lock on its mailbox. CPU writes to that control word are dropped until software clears the flag, so a mailbox that has just completed cannot be reused before its completion has been acknowledged.

Top module: `mb_txdone_unit`

## Requirements
- R1: After reset every control word, the flag register and the mask register read as zero, and `irq` is low.
- R2: The clock edge that samples `tx_done` high copies `timer` into bits [15:0] of the control word of mailbox `tx_idx`.
- R3: On completion, a mailbox whose code (control word bits [19:16]) is 4'b1100 with the remote bit (bit 20) clear gets code 4'b1000.
- R4: On completion, a mailbox whose code is 4'b1100 with the remote bit set gets code 4'b0100.
- R5: On completion, any other code is kept unchanged, and the remote bit is kept in every case.
- R6: Completion sets bit `tx_idx` of the flag register and leaves the other flag bits unchanged.
- R7: A CPU write to the flag register (`cpu_sel`=1) clears every flag whose data bit is one and leaves flags whose data bit is zero unchanged.
- R8: When a completion and a flag clear hit the same mailbox in the same cycle, its flag ends up set.
- R9: `irq` is high exactly when some mailbox has both its flag bit and its mask bit set. It follows register changes in the cycle after the causing edge.
- R10: With `abort_en` high, a CPU control-word write (`cpu_sel`=0) to a mailbox whose flag is set changes nothing. With `abort_en` low, or with the flag clear, the write updates the code and the remote bit.
- R11: A completion and a CPU control-word write to the same mailbox in the same cycle apply the completion. The CPU write is discarded.
- R12: A CPU write with `cpu_sel`=2 loads the mask register, and a read with `cpu_sel`=2 returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| abort_en | input | 1 | Abort mode: a raised flag locks its mailbox against CPU writes |
| tx_done | input | 1 | Successful transmission strobe, one cycle |
| tx_idx | input | IDX_W | Mailbox that completed |
| timer | input | TS_W | Free-running timer value |
| cpu_we | input | 1 | CPU write enable |
| cpu_sel | input | 2 | 0 control word, 1 flags, 2 mask |
| cpu_addr | input | IDX_W | Mailbox index for control-word access |
| cpu_wdata | input | 32 | CPU write data |
| cpu_rdata | output | 32 | Combinational read of the selected register |
| irq | output | 1 | OR over mailboxes of flag AND mask |

## Verification
The assertions assume that `tx_idx` and `cpu_addr` always name an existing mailbox. They also assume that `tx_done` lasts one cycle per completion. The stimulus keeps to these limits by sweeping indices only over the configured mailbox count and by driving each strobe for exactly one clock. Same-cycle collisions between a completion and a CPU access are produced only in the dedicated tests for R8 and R11. The lock property ignores cycles that also carry a completion, because in those cycles the completion legitimately changes the code.

// File: rtl/mb_txdone_unit.sv
module mb_txdone_unit #(
  parameter int NUM_MB = 8,
  parameter int TS_W   = 16,
  parameter int IDX_W  = $clog2(NUM_MB)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              abort_en,
  input  logic              tx_done,
  input  logic [IDX_W-1:0]  tx_idx,
  input  logic [TS_W-1:0]   timer,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_sel,
  input  logic [IDX_W-1:0]  cpu_addr,
  input  logic [31:0]       cpu_wdata,
  output logic [31:0]       cpu_rdata,
  output logic              irq
);
  localparam int CODE_LSB = TS_W;
  localparam int RTR_BIT  = TS_W + 4;
  localparam logic [1:0] SEL_MB = 2'd0, SEL_FLAG = 2'd1, SEL_MASK = 2'd2;

  logic [NUM_MB-1:0][TS_W-1:0] stamp_q;
  logic [NUM_MB-1:0][3:0]      code_q;
  logic [NUM_MB-1:0]           rtr_q, flag_q, mask_q;
  logic [NUM_MB-1:0]           hit_done, hit_cpu, clr;

  logic unused_wdata;
  assign unused_wdata = ^cpu_wdata;

  for (genvar g = 0; g < NUM_MB; g++) begin : g_hit
    assign hit_done[g] = tx_done && (tx_idx == IDX_W'(g));
    assign hit_cpu[g]  = cpu_we && (cpu_sel == SEL_MB) && (cpu_addr == IDX_W'(g))
                         && !(abort_en && flag_q[g]);
    assign clr[g]      = cpu_we && (cpu_sel == SEL_FLAG) && cpu_wdata[g];
  end

  function automatic logic [3:0] done_code(input logic [3:0] c, input logic r);
    if (c == 4'b1100) return r ? 4'b0100 : 4'b1000;
    return c;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stamp_q <= '0;
      code_q  <= '0;
      rtr_q   <= '0;
      flag_q  <= '0;
      mask_q  <= '0;
    end else begin
      for (int i = 0; i < NUM_MB; i++) begin
        if (hit_done[i]) begin
          stamp_q[i] <= timer;
          code_q[i]  <= done_code(code_q[i], rtr_q[i]);
        end else if (hit_cpu[i]) begin
          code_q[i]  <= cpu_wdata[CODE_LSB +: 4];
          rtr_q[i]   <= cpu_wdata[RTR_BIT];
        end
      end
      flag_q <= hit_done | (flag_q & ~clr);
      if (cpu_we && cpu_sel == SEL_MASK) mask_q <= cpu_wdata[NUM_MB-1:0];
    end
  end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_sel)
      SEL_MB: begin
        cpu_rdata[TS_W-1:0]        = stamp_q[cpu_addr];
        cpu_rdata[CODE_LSB +: 4]   = code_q[cpu_addr];
        cpu_rdata[RTR_BIT]         = rtr_q[cpu_addr];
      end
      SEL_FLAG: cpu_rdata[NUM_MB-1:0] = flag_q;
      SEL_MASK: cpu_rdata[NUM_MB-1:0] = mask_q;
      default:  cpu_rdata = '0;
    endcase
  end

  assign irq = |(flag_q & mask_q);
endmodule

module mb_txdone_chk #(
  parameter int NUM_MB = 8,
  parameter int TS_W   = 16,
  parameter int IDX_W  = $clog2(NUM_MB)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        abort_en,
  input logic                        tx_done,
  input logic [IDX_W-1:0]            tx_idx,
  input logic [TS_W-1:0]             timer,
  input logic                        cpu_we,
  input logic [1:0]                  cpu_sel,
  input logic [IDX_W-1:0]            cpu_addr,
  input logic [31:0]                 cpu_wdata,
  input logic                        irq,
  input logic [NUM_MB-1:0]           flag_q,
  input logic [NUM_MB-1:0]           mask_q,
  input logic [NUM_MB-1:0][3:0]      code_q,
  input logic [NUM_MB-1:0][TS_W-1:0] stamp_q
);
  // R2
  stamp_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> stamp_q[$past(tx_idx)] == $past(timer));
  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> flag_q[$past(tx_idx)]);
  // R7
  flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_sel == 2'd1 && !tx_done) |=> (flag_q & $past(cpu_wdata[NUM_MB-1:0])) == '0);
  // R9
  irq_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_done && mask_q[tx_idx] && !(cpu_we && cpu_sel == 2'd2)) |=> irq);
  // R10
  abort_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_sel == 2'd0 && abort_en && flag_q[cpu_addr] && !tx_done)
      |=> code_q[$past(cpu_addr)] == $past(code_q[cpu_addr]));
endmodule

bind mb_txdone_unit mb_txdone_chk #(.NUM_MB(NUM_MB), .TS_W(TS_W), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/mb_txdone_unit_bench.sv
module mb_txdone_unit_bench;
  localparam int N = 8;
  logic        clk = 0, rst_n = 0, abort_en = 0, tx_done = 0, cpu_we = 0;
  logic [2:0]  tx_idx = 0, cpu_addr = 0;
  logic [15:0] timer = 0;
  logic [1:0]  cpu_sel = 0;
  logic [31:0] cpu_wdata = 0, cpu_rdata;
  logic        irq;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mb_txdone_unit u_mb_txdone_unit (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic d, input int idx, input logic [15:0] t,
                     input logic we, input logic [1:0] sel, input int addr, input logic [31:0] data);
    @(negedge clk);
    tx_done = d; tx_idx = 3'(idx); timer = t;
    cpu_we = we; cpu_sel = sel; cpu_addr = 3'(addr); cpu_wdata = data;
    @(negedge clk);
    tx_done = 0; cpu_we = 0;
  endtask

  task automatic wr(input logic [1:0] sel, input int addr, input logic [31:0] data);
    cyc(0, 0, 0, 1, sel, addr, data);
  endtask

  task automatic done(input int idx, input logic [15:0] t);
    cyc(1, idx, t, 0, 0, 0, 0);
  endtask

  task automatic rd(input logic [1:0] sel, input int addr, output logic [31:0] v);
    cpu_sel = sel; cpu_addr = 3'(addr);
    #1 v = cpu_rdata;
  endtask

  function automatic logic [31:0] ctl(input logic [3:0] c, input logic r);
    return {11'b0, r, c, 16'b0};
  endfunction

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] v;
    logic [3:0] ec;
    logic [15:0] t;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    for (int m = 0; m < N; m++) begin rd(0, m, v); chk("R1 ctrl", v, 0); end
    rd(1, 0, v); chk("R1 flags", v, 0);
    rd(2, 0, v); chk("R1 mask", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);

    // R2-R6 sweep over mailbox, code and remote bit
    for (int m = 0; m < N; m++)
      for (int c = 0; c < 16; c++)
        for (int r = 0; r < 2; r++) begin
          t = 16'(m * 4099 + c * 257 + r * 31 + 7);
          wr(0, m, ctl(4'(c), r[0]));
          done(m, t);
          ec = (c == 12) ? (r ? 4'b0100 : 4'b1000) : 4'(c);
          rd(0, m, v);
          chk("R2 stamp", {16'b0, v[15:0]}, {16'b0, t});
          chk(c == 12 ? (r ? "R4 code" : "R3 code") : "R5 code", {28'b0, v[19:16]}, {28'b0, ec});
          chk("R5 rtr", {31'b0, v[20]}, {31'b0, r[0]});
          rd(1, 0, v);
          chk("R6 flags", v, 32'(1 << m));
          wr(1, 0, 32'hFF);
        end

    // R9 irq over every mask with flags 8'hA5
    done(0, 1); done(2, 2); done(5, 3); done(7, 4);
    for (int k = 0; k < 256; k++) begin
      wr(2, 0, 32'(k));
      #1 chk("R9 irq", {31'b0, irq}, {31'b0, |(8'(k) & 8'hA5)});
    end
    // R12 mask readback
    wr(2, 0, 32'h3C);
    rd(2, 0, v); chk("R12 mask", v, 32'h3C);

    // R7 write-one-to-clear
    wr(1, 0, 32'h0F);
    rd(1, 0, v); chk("R7 partial clear", v, 32'hA0);
    wr(1, 0, 32'h00);
    rd(1, 0, v); chk("R7 zero write", v, 32'hA0);
    #1 chk("R9 irq after clear", {31'b0, irq}, {31'b0, |(8'h3C & 8'hA0)});

    // R8 set wins over clear
    wr(1, 0, 32'hFF);
    cyc(1, 3, 16'h1234, 1, 1, 0, 32'hFF);
    rd(1, 0, v); chk("R8 set beats clear", v, 32'h08);

    // R10 abort lock
    abort_en = 1;
    rd(0, 3, v); ec = v[19:16];
    wr(0, 3, ctl(4'b0011, 0));
    rd(0, 3, v); chk("R10 locked write", {28'b0, v[19:16]}, {28'b0, ec});
    wr(1, 0, 32'h08);
    wr(0, 3, ctl(4'b0011, 1));
    rd(0, 3, v); chk("R10 unlocked code", {28'b0, v[19:16]}, 32'h3);
    chk("R10 unlocked rtr", {31'b0, v[20]}, 1);
    abort_en = 0;
    done(3, 16'h0101);
    wr(0, 3, ctl(4'b0110, 0));
    rd(0, 3, v); chk("R10 abort off write", {28'b0, v[19:16]}, 32'h6);

    // R11 completion beats same-cycle CPU write
    wr(0, 2, ctl(4'b1100, 0));
    cyc(1, 2, 16'hBEEF, 1, 0, 2, ctl(4'b0001, 1));
    rd(0, 2, v);
    chk("R11 code", {28'b0, v[19:16]}, 32'h8);
    chk("R11 stamp", {16'b0, v[15:0]}, 32'hBEEF);
    chk("R11 rtr", {31'b0, v[20]}, 0);

    finish_run();
  end
endmodule